// File: doc/BRIEF.md
# Receive FIFO with break insertion

This block is the receive-side holding queue of a serial port. Bytes arrive from a deserializer one per cycle, and a line monitor may signal a break condition, which the queue records as a zero byte while also raising a sticky break-change flag. The host side pops the oldest byte when it reads the receive buffer. The oldest byte is visible combinationally on the read data port, and the pop advances the queue at the clock edge.

The block keeps a receiver-ready flag and a queue-full flag for the register front-end, and it drives a ready signal back to the deserializer. That ready signal is high only while reception is enabled and the queue is not full. A flush command from the front-end empties the queue. A separate clear input, driven by the command decoder, is the only way to drop the break-change flag.

Top module: `rx_break_fifo`

## Requirements
- R1: The queue holds at most four bytes and returns them oldest first. `rd_data` shows the oldest held byte whenever at least one is held, and a pop advances the queue at the next rising clock edge.
- R2: A pop while the queue is empty returns 0 on `rd_data` and changes no flag and no stored byte.
- R3: Any push sets `rx_ready_flag`. `full_flag` sets when the held count reaches four.
- R4: A pop without a push clears `full_flag`. `rx_ready_flag` clears only when the pop leaves the queue empty.
- R5: A push without a pop while four bytes are held replaces the newest byte. The count stays at four and the three older bytes keep their order.
- R6: A `brk_evt` pulse pushes a zero byte and sets `brk_flag`. When `in_valid` is high in the same cycle, the zero byte is stored and the deserializer byte is dropped.
- R7: `brk_flag` clears only on `brk_clr`. A `brk_evt` in the same cycle as `brk_clr` leaves the flag set, and a flush does not touch it.
- R8: `accept` is high exactly when `rx_en` is high and `full_flag` is low.
- R9: `flush` empties the queue and clears `rx_ready_flag` and `full_flag`, and it takes priority over a push or a pop in the same cycle.
- R10: A push and a pop in the same cycle are applied as pop-then-push. With one to four bytes held, the count is unchanged and order is kept; `full_flag` therefore stays set at four. On an empty queue, the pop returns 0 and the new byte is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_en | input | 1 | Receiver enable level from the front-end |
| flush | input | 1 | Empty the queue (one-cycle pulse) |
| brk_clr | input | 1 | Clear the break-change flag |
| in_valid | input | 1 | Deserializer byte present this cycle |
| in_data | input | DATA_W | Deserializer byte |
| brk_evt | input | 1 | Break detected on the line (one-cycle pulse) |
| rd_pop | input | 1 | Host reads the receive buffer this cycle |
| rd_data | output | DATA_W | Oldest held byte, 0 when empty |
| rx_ready_flag | output | 1 | At least one byte held |
| full_flag | output | 1 | Four bytes held |
| brk_flag | output | 1 | Sticky break-change flag |
| accept | output | 1 | Deserializer may deliver another byte |

## Verification
Three things can coincide in one cycle: a push, either a deserializer byte or a break, and a host pop. The bench provokes this with the queue empty, holding one byte, and holding four. A reference queue in the bench pops first and then pushes, and each later read must return bytes in the model's order while the flags match the model's size. It also sets a break and its clear in the same cycle, and a flush together with a push, and then checks that the flag is still set and that the queue is empty.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  // Count after one cycle, applying pop before push.
  function automatic int unsigned rxq_next_count(int unsigned cnt, bit push, bit pop,
                                                 int unsigned depth);
    int unsigned base;
    base = pop ? cnt - 1 : cnt;
    if (push) base = (base >= depth) ? depth : base + 1;
    return base;
  endfunction

  // Slot written by a push, after the optional pop has shifted the queue.
  function automatic int unsigned rxq_write_slot(int unsigned cnt, bit pop,
                                                 int unsigned depth);
    int unsigned base;
    base = pop ? cnt - 1 : cnt;
    return (base >= depth) ? depth - 1 : base;
  endfunction
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              push,
  input  logic              pop_req,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic [CNT_W-1:0]  cnt,
  output logic              pop_ok
);
  import rxq_pkg::*;
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [DATA_W-1:0] slot_q [DEPTH];
  logic [DATA_W-1:0] slot_n [DEPTH];
  int unsigned       wr_idx;

  assign pop_ok = pop_req && (cnt != '0);
  assign dout   = (cnt != '0) ? slot_q[0] : '0;
  assign wr_idx = rxq_write_slot(int'(cnt), pop_ok, DEPTH);

  always_comb begin
    for (int i = 0; i < DEPTH; i++) slot_n[i] = slot_q[i];
    if (pop_ok)
      for (int i = 0; i < DEPTH - 1; i++) slot_n[i] = slot_q[i + 1];
    if (push)
      for (int i = 0; i < DEPTH; i++)
        if (wr_idx == i) slot_n[i] = din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
    end else if (flush) begin
      cnt <= '0;
    end else begin
      cnt <= CNT_W'(rxq_next_count(int'(cnt), push, pop_ok, DEPTH));
      for (int i = 0; i < DEPTH; i++) slot_q[i] <= slot_n[i];
    end
  end

  a_r1_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULL_CNT);
  a_r2_empty_pop_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && cnt == '0 && !push && !flush) |=> (cnt == '0));
  a_r5_full_push_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop_req && cnt == FULL_CNT && !flush) |=> (cnt == FULL_CNT));
  a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (cnt == '0));
  a_r10_pushpop_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop_ok && !flush) |=> (cnt == $past(cnt)));
endmodule

// File: rtl/rxq_flags.sv
module rxq_flags #(
  parameter int DEPTH = 4,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic             pop_ok,
  input  logic [CNT_W-1:0] cnt,
  input  logic             brk_evt,
  input  logic             brk_clr,
  input  logic             rx_en,
  output logic             rdy_q,
  output logic             full_q,
  output logic             brk_q,
  output logic             accept
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] ONE_CNT  = CNT_W'(1);

  logic [CNT_W-1:0] base_cnt;
  assign base_cnt = pop_ok ? cnt - ONE_CNT : cnt;
  assign accept   = rx_en && !full_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q  <= 1'b0;
      full_q <= 1'b0;
    end else if (flush) begin
      rdy_q  <= 1'b0;
      full_q <= 1'b0;
    end else if (push) begin
      rdy_q  <= 1'b1;
      full_q <= (base_cnt >= LAST_CNT);
    end else if (pop_ok) begin
      full_q <= 1'b0;
      if (cnt == ONE_CNT) rdy_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        brk_q <= 1'b0;
    else if (brk_evt)  brk_q <= 1'b1;
    else if (brk_clr)  brk_q <= 1'b0;
  end

  a_r3_full_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    full_q == (cnt == FULL_CNT));
  a_r4_ready_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_q == (cnt != '0));
  a_r6_break_sets: assert property (@(posedge clk) disable iff (!rst_n)
    brk_evt |=> brk_q);
  a_r7_break_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_q && !brk_clr) |=> brk_q);
endmodule

// File: rtl/rx_break_fifo.sv
module rx_break_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              flush,
  input  logic              brk_clr,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              brk_evt,
  input  logic              rd_pop,
  output logic [DATA_W-1:0] rd_data,
  output logic              rx_ready_flag,
  output logic              full_flag,
  output logic              brk_flag,
  output logic              accept
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic              push_any;
  logic [DATA_W-1:0] push_byte;
  logic              pop_ok;
  logic [CNT_W-1:0]  held;

  // A break wins over a byte in the same cycle and is stored as zero.
  assign push_any  = in_valid || brk_evt;
  assign push_byte = brk_evt ? '0 : in_data;

  rxq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_store (
    .clk(clk), .rst_n(rst_n), .flush(flush), .push(push_any), .pop_req(rd_pop),
    .din(push_byte), .dout(rd_data), .cnt(held), .pop_ok(pop_ok)
  );

  rxq_flags #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_flags (
    .clk(clk), .rst_n(rst_n), .flush(flush), .push(push_any), .pop_ok(pop_ok),
    .cnt(held), .brk_evt(brk_evt), .brk_clr(brk_clr), .rx_en(rx_en),
    .rdy_q(rx_ready_flag), .full_q(full_flag), .brk_q(brk_flag), .accept(accept)
  );

  a_r8_accept_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && rx_en && !full_flag) || (!accept && (!rx_en || full_flag)));
  a_r2_empty_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_ready_flag |-> (rd_data == '0));
endmodule

// File: tb/rx_break_fifo_tb.sv
module rx_break_fifo_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_en = 0, flush = 0, brk_clr = 0, in_valid = 0, brk_evt = 0, rd_pop = 0;
  logic [DW-1:0] in_data = '0;
  logic [DW-1:0] rd_data;
  logic rx_ready_flag, full_flag, brk_flag, accept;

  int total = 0, bad = 0;
  logic [DW-1:0] model_q[$];
  bit model_brk = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_break_fifo u_dut (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .flush(flush), .brk_clr(brk_clr),
    .in_valid(in_valid), .in_data(in_data), .brk_evt(brk_evt), .rd_pop(rd_pop),
    .rd_data(rd_data), .rx_ready_flag(rx_ready_flag), .full_flag(full_flag),
    .brk_flag(brk_flag), .accept(accept)
  );

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_flags(string req);
    check(rx_ready_flag == (model_q.size() > 0), {req, " ready"}, rx_ready_flag, model_q.size() > 0);
    check(full_flag == (model_q.size() == 4), {req, " full"}, full_flag, model_q.size() == 4);
    check(brk_flag == model_brk, {req, " break"}, brk_flag, model_brk);
    check(accept == (rx_en && model_q.size() != 4), {req, " R8 accept"}, accept,
          rx_en && model_q.size() != 4);
  endtask

  // Driver: applies one cycle of stimulus, updates the reference queue;
  // the monitor part compares the popped byte against the queue head.
  task automatic step(bit p_push, logic [DW-1:0] d, bit p_brk, bit p_pop,
                      bit p_fl, bit p_clr, string req);
    logic [DW-1:0] exp_rd;
    in_valid = p_push; in_data = d; brk_evt = p_brk; rd_pop = p_pop;
    flush = p_fl; brk_clr = p_clr;
    #1;
    exp_rd = (model_q.size() > 0) ? model_q[0] : '0;
    if (p_pop) check(rd_data == exp_rd, {req, " read"}, rd_data, exp_rd);
    @(posedge clk);
    if (p_fl) model_q.delete();
    else begin
      if (p_pop && model_q.size() > 0) void'(model_q.pop_front());
      if (p_push || p_brk) begin
        if (model_q.size() == 4) model_q[3] = p_brk ? '0 : d;
        else model_q.push_back(p_brk ? '0 : d);
      end
    end
    if (p_brk) model_brk = 1;
    else if (p_clr) model_brk = 0;
    #1;
    in_valid = 0; brk_evt = 0; rd_pop = 0; flush = 0; brk_clr = 0;
    @(negedge clk);
    check_flags(req);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    bad++; total++;
    $display("FAIL watchdog expired R1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(rd_data == 0, "R2 reset read", rd_data, 0);
    check_flags("R1 reset");
    rst_n = 1;
    @(negedge clk);
    rx_en = 1;
    #1;
    check(accept == 1, "R8 enable", accept, 1);
    step(0, 8'h00, 0, 1, 0, 0, "R2 empty pop");
    step(1, 8'hA1, 0, 0, 0, 0, "R3 push1");
    step(1, 8'hB2, 0, 0, 0, 0, "R3 push2");
    step(1, 8'hC3, 0, 0, 0, 0, "R3 push3");
    step(1, 8'hD4, 0, 0, 0, 0, "R3 push4 full");
    step(1, 8'hE5, 0, 0, 0, 0, "R5 overwrite newest");
    step(1, 8'h66, 0, 1, 0, 0, "R10 pushpop at four");
    step(0, 8'h00, 0, 1, 0, 0, "R4 pop clears full");
    step(0, 8'h00, 0, 1, 0, 0, "R1 order");
    step(0, 8'h00, 0, 1, 0, 0, "R5 replaced byte");
    step(0, 8'h00, 0, 1, 0, 0, "R4 last pop");
    step(1, 8'h77, 0, 1, 0, 0, "R10 pushpop empty");
    step(1, 8'h88, 0, 1, 0, 0, "R10 pushpop one");
    step(1, 8'h99, 1, 0, 0, 0, "R6 break over byte");
    step(0, 8'h00, 1, 0, 0, 1, "R7 set wins clear");
    step(0, 8'h00, 0, 1, 0, 0, "R1 after break");
    step(0, 8'h00, 0, 1, 0, 0, "R6 zero byte");
    step(0, 8'h00, 0, 1, 0, 0, "R6 second zero");
    step(1, 8'h12, 0, 0, 0, 0, "R3 refill");
    step(1, 8'h34, 0, 1, 1, 0, "R9 flush priority");
    step(0, 8'h00, 0, 1, 0, 0, "R9 empty after flush");
    step(0, 8'h00, 0, 0, 0, 1, "R7 explicit clear");
    rx_en = 0;
    step(0, 8'h00, 0, 0, 0, 0, "R8 disable");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule